// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the control and status registers of a small multi-cycle RV32 core that only ever runs at machine privilege. Each cycle in which the execute stage presents a retiring instruction (`valid_i`), the unit does three things. It serves a CSR read-modify-write in write, set or clear form, and returns the old value. It takes a synchronous exception, a timer interrupt or a trap return. When it redirects the fetch, it supplies the next PC.

A free-running counter can be read through the cycle, time and machine-cycle addresses. A compare register at custom address 0x7C0 raises the machine timer interrupt when the counter reaches it. Each optional register is switched on by its own parameter. When the programmable trap vector is disabled, every trap enters at `RESET_VECTOR + ISR_OFFSET`. Decode supplies the CSR operand already resolved, whether it is the register or the immediate form.

Top module: `csr_trap_unit`

## Requirements
- R1: After reset, the status register (0x300) reads 0x0000_1800: the previous-privilege bits [12:11] read 11, interrupt enable bit 3 is 0 and saved enable bit 7 is 0. The cause register (0x342) reads 0 and the pending register (0x344) reads 0. The vector register (0x305) reads RESET_VECTOR+ISR_OFFSET.
- R2: The operation code selects how the CSR is updated: 1 writes the operand, 2 ORs it in, 3 clears the bits set in it, and 0 makes no access. The read data is always the value before the update. The scratch register (0x340) and the exception PC (0x341) are fully read/write.
- R3: When a trap is taken, the exception PC register takes `pc_i`. Bit 7 of the status register takes the old bit 3, and bit 3 is cleared. The CSR update of that instruction is suppressed.
- R4: Exceptions are ranked as follows, and the cause register takes the matching code: illegal opcode (2), then environment call (11), then breakpoint (3), then load misalignment (4), then store misalignment (6).
- R5: The trap-value register (0x343) takes `mem_addr_i` for a misaligned access and `instr_i` for an illegal opcode. It takes 0 for an environment call or a breakpoint.
- R6: Misaligned accesses trap only when TRAP_ALIGN=1. Illegal opcodes, and accesses to unimplemented CSRs, trap only when TRAP_ILLEGAL=1. Otherwise `redirect_o` stays low.
- R7: A trap redirects to the vector register when SUPPORT_MTVEC=1; writes to that register clear bits [1:0]. When SUPPORT_MTVEC=0, a trap redirects to RESET_VECTOR+ISR_OFFSET.
- R8: A trap return without a trap redirects to the exception PC. Status bit 3 takes bit 7, and bit 7 is set.
- R9: The counter advances by one every clock. It reads the same value at 0xC00, 0xC01 and 0xB00, and writes to it are ignored.
- R10: The pending timer bit (bit 7 of 0x344) is set once the counter equals the compare register (0x7C0). A write to the compare register clears it.
- R11: An interrupt is taken on a valid instruction only when status bit 3, enable bit 7 (0x304) and pending bit 7 are all set. It writes cause 0x8000_0007. An exception in the same cycle takes precedence.
- R12: An unimplemented or disabled CSR address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction retiring this cycle |
| pc_i | input | 32 | PC of that instruction |
| instr_i | input | 32 | Instruction word |
| csr_op_i | input | 2 | 0 none, 1 write, 2 set, 3 clear |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Resolved CSR operand |
| csr_rdata_o | output | 32 | Old CSR value |
| ecall_i | input | 1 | Environment call |
| ebreak_i | input | 1 | Breakpoint |
| illegal_i | input | 1 | Invalid opcode seen by decode |
| ld_misalign_i | input | 1 | Misaligned load |
| st_misalign_i | input | 1 | Misaligned store |
| mem_addr_i | input | 32 | Access address |
| mret_i | input | 1 | Trap return |
| redirect_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | 32 | Redirect target |
| epc_o | output | 32 | Saved exception PC |

## Verification
Some behaviours are checked on every cycle by properties:
- the enable save and clear on trap entry, the capture of the faulting PC, and the suppression of the CSR update;
- the restore on trap return;
- that an interrupt is taken only with all three gates open;
- the counter step and the clear of the pending bit on a compare write.

Other behaviours only the bench scenarios can show: the read-modify-write results, the cause ranking when several sources fire together, the trap-value contents, the counter reaching the compare value, and the fixed-vector and no-trap behaviour of a second instance built with the optional features off.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_IEN     = 12'h304;
  localparam logic [11:0] A_VEC     = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;
  localparam logic [11:0] A_IPEND   = 12'h344;
  localparam logic [11:0] A_TCMP    = 12'h7C0;
  localparam logic [11:0] A_MCYC    = 12'hB00;
  localparam logic [11:0] A_CYC     = 12'hC00;
  localparam logic [11:0] A_TIME    = 12'hC01;

  localparam logic [3:0] C_ILLEGAL = 4'd2;
  localparam logic [3:0] C_BREAK   = 4'd3;
  localparam logic [3:0] C_LDMIS   = 4'd4;
  localparam logic [3:0] C_STMIS   = 4'd6;
  localparam logic [3:0] C_TIMER   = 4'd7;
  localparam logic [3:0] C_ECALL   = 4'd11;

  typedef struct packed {
    logic        take;
    logic        is_irq;
    logic [3:0]  code;
    logic [31:0] tval;
  } trap_info_t;
endpackage

// File: rtl/csr_cycle_timer.sv
module csr_cycle_timer #(
  parameter int unsigned CNT_W   = 32,
  parameter bit          HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] count_q, count_d;

  always_comb count_d = count_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count_q == $past(count_q) + CNT_W'(1));

  generate
    if (HAS_CMP) begin : g_cmp
      logic [CNT_W-1:0] cmp_q, cmp_d;
      logic             pend_q, pend_d;

      always_comb begin
        cmp_d  = cmp_we ? cmp_wdata : cmp_q;
        pend_d = pend_q;
        if (cmp_we)                 pend_d = 1'b0;
        else if (count_q == cmp_q)  pend_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmp_q  <= '1;
          pend_q <= 1'b0;
        end else begin
          if (cmp_we) cmp_q <= cmp_d;
          pend_q <= pend_d;
        end
      end

      assign cmp_o  = cmp_q;
      assign pend_o = pend_q;

      // R10
      cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !pend_q);
    end else begin : g_nocmp
      logic unused_cmp;
      assign unused_cmp = cmp_we ^ (^cmp_wdata);
      assign cmp_o  = '1;
      assign pend_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/csr_trap_select.sv
module csr_trap_select
  import csr_trap_pkg::*;
#(
  parameter bit TRAP_ALIGN   = 1'b1,
  parameter bit TRAP_ILLEGAL = 1'b1
) (
  input  logic        valid_i,
  input  logic        illegal_i,
  input  logic        bad_csr_i,
  input  logic        ecall_i,
  input  logic        ebreak_i,
  input  logic        ld_mis_i,
  input  logic        st_mis_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] mem_addr_i,
  input  logic        irq_ready_i,
  output trap_info_t  trap_o
);
  always_comb begin
    trap_o = '0;
    if (valid_i) begin
      if (TRAP_ILLEGAL && (illegal_i || bad_csr_i)) begin
        trap_o = '{take: 1'b1, is_irq: 1'b0, code: C_ILLEGAL, tval: instr_i};
      end else if (ecall_i) begin
        trap_o = '{take: 1'b1, is_irq: 1'b0, code: C_ECALL, tval: '0};
      end else if (ebreak_i) begin
        trap_o = '{take: 1'b1, is_irq: 1'b0, code: C_BREAK, tval: '0};
      end else if (TRAP_ALIGN && ld_mis_i) begin
        trap_o = '{take: 1'b1, is_irq: 1'b0, code: C_LDMIS, tval: mem_addr_i};
      end else if (TRAP_ALIGN && st_mis_i) begin
        trap_o = '{take: 1'b1, is_irq: 1'b0, code: C_STMIS, tval: mem_addr_i};
      end else if (irq_ready_i) begin
        trap_o = '{take: 1'b1, is_irq: 1'b1, code: C_TIMER, tval: '0};
      end
    end
  end
endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
  import csr_trap_pkg::*;
#(
  parameter logic [31:0] RESET_VECTOR     = 32'h8000_0000,
  parameter logic [31:0] ISR_OFFSET       = 32'h0000_0010,
  parameter bit          SUPPORT_MTVEC    = 1'b1,
  parameter bit          SUPPORT_MTVAL    = 1'b1,
  parameter bit          SUPPORT_MIP_MIE  = 1'b1,
  parameter bit          SUPPORT_MSCRATCH = 1'b1,
  parameter bit          SUPPORT_MCYCLE   = 1'b1,
  parameter bit          SUPPORT_MTIMECMP = 1'b1,
  parameter bit          TRAP_ALIGN       = 1'b1,
  parameter bit          TRAP_ILLEGAL     = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  input  logic [1:0]  csr_op_i,
  input  logic [11:0] csr_addr_i,
  input  logic [31:0] csr_wdata_i,
  output logic [31:0] csr_rdata_o,
  input  logic        ecall_i,
  input  logic        ebreak_i,
  input  logic        illegal_i,
  input  logic        ld_misalign_i,
  input  logic        st_misalign_i,
  input  logic [31:0] mem_addr_i,
  input  logic        mret_i,
  output logic        redirect_o,
  output logic [31:0] redirect_pc_o,
  output logic [31:0] epc_o
);
  localparam int unsigned XW       = 32;
  localparam logic [XW-1:0] FIXED_VEC = RESET_VECTOR + ISR_OFFSET;
  localparam int unsigned IE_BIT   = 3;
  localparam int unsigned PIE_BIT  = 7;
  localparam int unsigned TIM_BIT  = 7;

  csr_op_e    op;
  trap_info_t trap;
  logic       hit, access, bad_csr, wr_en, mret_take, state_en, irq_ready;
  logic [XW-1:0] rd_val, wval, count, cmp_val;
  logic       tmr_pend, cmp_we;

  logic          ie_q, ie_d, pie_q, pie_d, tie_q, tie_d;
  logic [XW-1:0] vec_q, vec_d, scratch_q, scratch_d, epc_q, epc_d;
  logic [XW-1:0] cause_q, cause_d, tval_q, tval_d;

  assign op      = csr_op_e'(csr_op_i);
  assign access  = valid_i && (op != OP_NONE);
  assign bad_csr = access && !hit;

  always_comb begin
    hit    = 1'b1;
    rd_val = '0;
    case (csr_addr_i)
      A_STATUS: rd_val = 32'h0000_1800 | (XW'(pie_q) << PIE_BIT) | (XW'(ie_q) << IE_BIT);
      A_EPC:    rd_val = epc_q;
      A_CAUSE:  rd_val = cause_q;
      A_VEC:    if (SUPPORT_MTVEC)    rd_val = vec_q;     else hit = 1'b0;
      A_TVAL:   if (SUPPORT_MTVAL)    rd_val = tval_q;    else hit = 1'b0;
      A_SCRATCH:if (SUPPORT_MSCRATCH) rd_val = scratch_q; else hit = 1'b0;
      A_IEN:    if (SUPPORT_MIP_MIE)  rd_val = XW'(tie_q) << TIM_BIT; else hit = 1'b0;
      A_IPEND:  if (SUPPORT_MIP_MIE)  rd_val = XW'(tmr_pend) << TIM_BIT; else hit = 1'b0;
      A_TCMP:   if (SUPPORT_MTIMECMP) rd_val = cmp_val;   else hit = 1'b0;
      A_MCYC, A_CYC, A_TIME:
                if (SUPPORT_MCYCLE)   rd_val = count;     else hit = 1'b0;
      default:  hit = 1'b0;
    endcase
  end

  assign csr_rdata_o = rd_val;

  always_comb begin
    case (op)
      OP_WRITE: wval = csr_wdata_i;
      OP_SET:   wval = rd_val | csr_wdata_i;
      OP_CLEAR: wval = rd_val & ~csr_wdata_i;
      default:  wval = rd_val;
    endcase
  end

  assign irq_ready = SUPPORT_MIP_MIE && ie_q && tie_q && tmr_pend;

  csr_trap_select #(.TRAP_ALIGN(TRAP_ALIGN), .TRAP_ILLEGAL(TRAP_ILLEGAL)) u_sel (
    .valid_i(valid_i), .illegal_i(illegal_i), .bad_csr_i(bad_csr),
    .ecall_i(ecall_i), .ebreak_i(ebreak_i), .ld_mis_i(ld_misalign_i),
    .st_mis_i(st_misalign_i), .instr_i(instr_i), .mem_addr_i(mem_addr_i),
    .irq_ready_i(irq_ready), .trap_o(trap)
  );

  assign wr_en     = access && hit && !trap.take;
  assign mret_take = valid_i && mret_i && !trap.take;
  assign state_en  = trap.take || mret_take || wr_en;
  assign cmp_we    = wr_en && (csr_addr_i == A_TCMP);

  csr_cycle_timer #(.CNT_W(XW), .HAS_CMP(SUPPORT_MTIMECMP)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_wdata(wval),
    .count_o(count), .cmp_o(cmp_val), .pend_o(tmr_pend)
  );

  always_comb begin
    ie_d = ie_q; pie_d = pie_q; tie_d = tie_q;
    vec_d = vec_q; scratch_d = scratch_q; epc_d = epc_q;
    cause_d = cause_q; tval_d = tval_q;
    if (trap.take) begin
      epc_d   = pc_i;
      cause_d = {trap.is_irq, 27'b0, trap.code};
      tval_d  = SUPPORT_MTVAL ? trap.tval : '0;
      pie_d   = ie_q;
      ie_d    = 1'b0;
    end else begin
      if (mret_take) begin
        ie_d  = pie_q;
        pie_d = 1'b1;
      end
      if (wr_en) begin
        case (csr_addr_i)
          A_STATUS:  begin ie_d = wval[IE_BIT]; pie_d = wval[PIE_BIT]; end
          A_IEN:     tie_d     = wval[TIM_BIT];
          A_VEC:     vec_d     = {wval[XW-1:2], 2'b00};
          A_SCRATCH: scratch_d = wval;
          A_EPC:     epc_d     = wval;
          A_CAUSE:   cause_d   = wval;
          A_TVAL:    tval_d    = wval;
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0; pie_q <= 1'b0; tie_q <= 1'b0;
      vec_q <= FIXED_VEC; scratch_q <= '0; epc_q <= '0;
      cause_q <= '0; tval_q <= '0;
    end else if (state_en) begin
      ie_q <= ie_d; pie_q <= pie_d; tie_q <= tie_d;
      vec_q <= vec_d; scratch_q <= scratch_d; epc_q <= epc_d;
      cause_q <= cause_d; tval_q <= tval_d;
    end
  end

  assign redirect_o    = trap.take || mret_take;
  assign redirect_pc_o = trap.take ? (SUPPORT_MTVEC ? vec_q : FIXED_VEC) : epc_q;
  assign epc_o         = epc_q;

  // R3
  trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap.take |=> !ie_q && (pie_q == $past(ie_q)) && (epc_q == $past(pc_i)));

  // R3
  trap_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap.take |=> $stable(scratch_q));

  // R8
  mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mret_take |=> (ie_q == $past(pie_q)) && pie_q);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap.take && trap.is_irq) |-> (ie_q && tie_q && tmr_pend));
endmodule

// File: tb/sim_csr_trap_unit.sv
`timescale 1ns/1ps
module sim_csr_trap_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        valid, ecall, ebreak, illegal, ldm, stm, mret;
  logic [31:0] pc, instr, wdata, maddr;
  logic [1:0]  op;
  logic [11:0] addr;
  logic [31:0] rd0, rd1, rpc0, rpc1, epc0, epc1;
  logic        rdr0, rdr1;

  csr_trap_unit u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .pc_i(pc), .instr_i(instr),
    .csr_op_i(op), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rd0),
    .ecall_i(ecall), .ebreak_i(ebreak), .illegal_i(illegal),
    .ld_misalign_i(ldm), .st_misalign_i(stm), .mem_addr_i(maddr), .mret_i(mret),
    .redirect_o(rdr0), .redirect_pc_o(rpc0), .epc_o(epc0)
  );

  csr_trap_unit #(
    .SUPPORT_MTVEC(1'b0), .SUPPORT_MSCRATCH(1'b0),
    .TRAP_ALIGN(1'b0), .TRAP_ILLEGAL(1'b0)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .pc_i(pc), .instr_i(instr),
    .csr_op_i(op), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rd1),
    .ecall_i(ecall), .ebreak_i(ebreak), .illegal_i(illegal),
    .ld_misalign_i(ldm), .st_misalign_i(stm), .mem_addr_i(maddr), .mret_i(mret),
    .redirect_o(rdr1), .redirect_pc_o(rpc1), .epc_o(epc1)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] c_rd0, c_rd1, c_pc0, c_pc1;
  logic        c_r0, c_r1;

  // {op, addr, operand, expected old value}
  localparam int NV = 11;
  localparam logic [77:0] TBL [NV] = '{
    {2'd1, 12'h340, 32'hA5A5_0000, 32'h0000_0000},
    {2'd2, 12'h340, 32'h0000_00FF, 32'hA5A5_0000},
    {2'd3, 12'h340, 32'hA500_000F, 32'hA5A5_00FF},
    {2'd2, 12'h340, 32'h0000_0000, 32'h00A5_00F0},
    {2'd1, 12'h305, 32'h0000_2003, 32'h8000_0010},
    {2'd2, 12'h305, 32'h0000_0000, 32'h0000_2000},
    {2'd1, 12'h341, 32'h1234_5678, 32'h0000_0000},
    {2'd2, 12'h341, 32'h0000_0000, 32'h1234_5678},
    {2'd1, 12'h300, 32'h0000_0088, 32'h0000_1800},
    {2'd2, 12'h300, 32'h0000_0000, 32'h0000_1888},
    {2'd1, 12'h300, 32'h0000_0000, 32'h0000_1888}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    valid = 0; ecall = 0; ebreak = 0; illegal = 0; ldm = 0; stm = 0; mret = 0;
    pc = 32'h0; instr = 32'h0; wdata = 32'h0; maddr = 32'h0; op = 2'd0; addr = 12'h0;
  endtask

  task automatic issue();
    valid = 1'b1;
    #2;
    c_rd0 = rd0; c_rd1 = rd1; c_pc0 = rpc0; c_pc1 = rpc1; c_r0 = rdr0; c_r1 = rdr1;
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic csr(input logic [1:0] o, input logic [11:0] a, input logic [31:0] d);
    op = o; addr = a; wdata = d; pc = 32'h40;
    issue();
  endtask

  task automatic rd(input logic [11:0] a);
    csr(2'd2, a, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] c1, c2, cbase;
    bit seen;
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(12'h300); chk("R1 status", c_rd0, 32'h0000_1800);
    rd(12'h342); chk("R1 cause", c_rd0, 32'h0);
    rd(12'h344); chk("R1 pending", c_rd0, 32'h0);

    // R2 R7 R12 table walk
    for (int i = 0; i < NV; i++) begin
      csr(TBL[i][77:76], TBL[i][75:64], TBL[i][63:32]);
      chk("R2 table", c_rd0, TBL[i][31:0]);
      chk("R2 table no redirect", {31'b0, c_r0}, 32'h0);
    end

    // R6 R7 R12 reduced instance
    ecall = 1; pc = 32'h500; issue();
    chk("R7 fixed vector", c_pc1, 32'h8000_0010);
    chk("R7 fixed vector taken", {31'b0, c_r1}, 32'h1);
    ldm = 1; maddr = 32'h1001; issue();
    chk("R6 align trap off", {31'b0, c_r1}, 32'h0);
    illegal = 1; instr = 32'h1111_2222; issue();
    chk("R6 illegal trap off", {31'b0, c_r1}, 32'h0);
    rd(12'h305);
    chk("R12 disabled vector reads zero", c_rd1, 32'h0);
    chk("R6 disabled CSR no trap", {31'b0, c_r1}, 32'h0);
    rd(12'h340);
    chk("R12 disabled scratch reads zero", c_rd1, 32'h0);

    // R3 R7 entry, R8 return
    csr(2'd1, 12'h300, 32'h8);
    ecall = 1; pc = 32'h100; issue();
    chk("R3 redirect", {31'b0, c_r0}, 32'h1);
    chk("R7 vector target", c_pc0, 32'h0000_2000);
    rd(12'h341); chk("R3 epc", c_rd0, 32'h100);
    rd(12'h342); chk("R4 ecall cause", c_rd0, 32'd11);
    rd(12'h343); chk("R5 ecall tval", c_rd0, 32'h0);
    rd(12'h300); chk("R3 status after entry", c_rd0, 32'h0000_1880);
    mret = 1; pc = 32'h104; issue();
    chk("R8 return target", c_pc0, 32'h100);
    chk("R8 return redirect", {31'b0, c_r0}, 32'h1);
    rd(12'h300); chk("R8 status after return", c_rd0, 32'h0000_1888);

    // R4 R5 R3 ranking and suppression
    illegal = 1; ecall = 1; ldm = 1; instr = 32'hDEAD_BEEF; maddr = 32'h1001;
    op = 2'd1; addr = 12'h340; wdata = 32'h5555; pc = 32'h200; issue();
    rd(12'h342); chk("R4 illegal first", c_rd0, 32'd2);
    rd(12'h343); chk("R5 illegal tval", c_rd0, 32'hDEAD_BEEF);
    rd(12'h340); chk("R3 write suppressed", c_rd0, 32'h00A5_00F0);
    ebreak = 1; ldm = 1; maddr = 32'h1001; issue();
    rd(12'h342); chk("R4 break over misalign", c_rd0, 32'd3);
    rd(12'h343); chk("R5 break tval", c_rd0, 32'h0);
    ldm = 1; stm = 1; maddr = 32'h1003; issue();
    rd(12'h342); chk("R4 load misalign", c_rd0, 32'd4);
    rd(12'h343); chk("R5 load tval", c_rd0, 32'h1003);
    stm = 1; maddr = 32'h2002; issue();
    rd(12'h342); chk("R4 store misalign", c_rd0, 32'd6);
    rd(12'h343); chk("R5 store tval", c_rd0, 32'h2002);
    instr = 32'h3013_0073; rd(12'h301);
    chk("R12 unimplemented reads zero", c_rd0, 32'h0);
    chk("R6 unimplemented traps", {31'b0, c_r0}, 32'h1);
    rd(12'h342); chk("R12 unimplemented cause", c_rd0, 32'd2);

    // R9 counter
    rd(12'hC00); c1 = c_rd0;
    repeat (5) @(posedge clk); #1;
    rd(12'hC00); c2 = c_rd0;
    chk("R9 counter step", c2 - c1, 32'd6);
    rd(12'hC01); chk("R9 time alias", c_rd0, c2 + 1);
    rd(12'hB00); chk("R9 mcycle alias", c_rd0, c2 + 2);
    csr(2'd1, 12'hC00, 32'h0); c1 = c_rd0;
    rd(12'hC00); chk("R9 write ignored", c_rd0, c1 + 1);

    // R10 R11 timer
    csr(2'd1, 12'h300, 32'h0);
    csr(2'd1, 12'h304, 32'h80);
    rd(12'hC00); cbase = c_rd0;
    csr(2'd1, 12'h7C0, cbase + 32'd20);
    rd(12'h344); chk("R10 not yet pending", c_rd0, 32'h0);
    seen = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      rd(12'h344);
      if (c_r0) chk("R11 no irq while disabled", 32'h1, 32'h0);
      if (c_rd0[7]) seen = 1'b1;
    end
    chk("R10 pending set", {31'b0, seen}, 32'h1);
    rd(12'hC00);
    chk("R10 counter passed compare", {31'b0, (c_rd0 >= cbase + 32'd20)}, 32'h1);
    csr(2'd1, 12'h300, 32'h8);
    ecall = 1; pc = 32'h280; issue();
    rd(12'h342); chk("R11 exception wins", c_rd0, 32'd11);
    csr(2'd1, 12'h300, 32'h8);
    pc = 32'h300; issue();
    chk("R11 irq redirect", {31'b0, c_r0}, 32'h1);
    rd(12'h342); chk("R11 irq cause", c_rd0, 32'h8000_0007);
    rd(12'h341); chk("R11 irq epc", c_rd0, 32'h300);
    csr(2'd1, 12'h7C0, 32'hFFFF_FFFF);
    rd(12'h344); chk("R10 compare write clears", c_rd0, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule